// File: doc/BRIEF.md
# Per-trigger event frame builder

Each accepted trigger makes this block emit one event frame on a 32-bit output stream. A frame opens with two header words: an all-zero word, then a word carrying the node's 8-bit address. Next comes the trigger time, taken from a 64-bit counter that counts from the most recent run start. After that the block forwards M multisample records of four words each, drawn from an upstream FIFO. The frame closes with one status tail word.

Upstream logic feeds records one word at a time with a valid/ready pair and tells the block when the event has no more records. A separate pulse reports each multisample the FIFO had to discard because it was backed up. A per-word flag reports that the sample frames merged into a record disagreed on their buffer address. The tail word gives the record count, the discard count and both error flags, so the consumer can judge the frame's integrity without any further context.

Top module: `evt_frame_builder`

## Requirements
- R1: A trigger that arrives while no frame is in progress makes `out_valid` rise on the next clock edge with a data word of zero. The word after it is `{24'b0, node_addr}`.
- R2: The 64-bit timestamp counter becomes 0 on the edge that samples `run_start` and rises by one on every other edge. The frame's third word is the counter's low half as sampled on the trigger edge, and its fourth word is the high half.
- R3: After the fourth word, `in_ready` is high. Each word accepted with `in_valid` appears on `out_data` one cycle later, in the order it arrived. Four consecutive accepted words form one record.
- R4: The record phase ends on an edge where `rec_done` is high, `in_valid` is low and a whole number of records has been accepted. The tail word is emitted on that edge with `out_last` high. A `rec_done` that arrives part-way through a record is ignored.
- R5: Tail bits 11:0 carry M, the number of complete records forwarded in the frame.
- R6: Tail bits 23:12 carry the number of `drop_pulse` cycles seen since the trigger was accepted. The count saturates at 4095.
- R7: Tail bit 27 is 1 exactly when at least one `drop_pulse` was seen, so a nonzero skip count appears only together with this bit.
- R8: Tail bit 26 is 1 when any accepted word of the frame had `in_sync_err` high.
- R9: Tail bits 31:28 and 25:24 are zero.
- R10: A trigger that arrives while a frame is in progress is ignored and causes no extra frame. The skip count and both flags start from zero in every new frame.
- R11: While reset is applied and after it is released, `out_valid`, `out_last` and `in_ready` are low until a trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Pulse that zeroes the timestamp counter |
| trigger | input | 1 | Pulse that requests one frame |
| node_addr | input | 8 | Static node address placed in header word 1 |
| in_valid | input | 1 | Record word present |
| in_data | input | 32 | Record word |
| in_sync_err | input | 1 | Buffer-address mismatch flag for this word |
| in_ready | output | 1 | Block accepts record words |
| rec_done | input | 1 | No further records for this event |
| drop_pulse | input | 1 | One multisample was discarded on FIFO backup |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the tail word |

## Verification
The bench sweeps M from 0 to 5 and crosses it with 0, 1 or 3 discards. Different patterns of address-mismatch flags are placed on different records, so a tail field that picked up the wrong source or stayed stale from an earlier frame would show up. Some frames have bubble cycles inside records, and some start a new run a variable number of cycles before the trigger. Together these separate a correct timestamp capture from an off-by-one, and show that forwarding holds up when input is irregular. One frame sends a spurious end request and a second trigger part-way through a record, to show that both are ignored. Another frame sends 4100 discards to drive the skip field to its saturation value.

// File: rtl/evt_frame_pkg.sv
// Package: shared widths, sequencer states and tail packing for the frame builder.
// Assumes a 32-bit output word and a 12-bit count field in the tail.
package evt_frame_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR1,
        ST_TSLO,
        ST_TSHI,
        ST_DATA
    } seq_state_t;

    // Packs the status tail: backup at 27, sync at 26, skip at 23:12, count at 11:0.
    function automatic logic [DATA_W-1:0] pack_tail(
        input logic [CNT_W-1:0] recs,
        input logic [CNT_W-1:0] skips,
        input logic             backup,
        input logic             sync_bad
    );
        return {4'b0000, backup, sync_bad, 2'b00, skips, recs};
    endfunction
endpackage

// File: rtl/evt_ts_counter.sv
// Module: free-running run-relative timestamp.
// Goes to zero on the edge that samples run_start, otherwise counts up by one each cycle.
module evt_ts_counter #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_start,
    output logic [TS_W-1:0] ts_now
);
    // Counter update: zero on reset or run start, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n || run_start) ts_now <= '0;
        else                     ts_now <= ts_now + 1'b1;
    end

    AST_TS_RUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (ts_now == '0)); // R2
    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !run_start |=> (ts_now == $past(ts_now) + 1'b1)); // R2
endmodule

// File: rtl/evt_status_track.sv
// Module: per-frame status bookkeeping for the tail word.
// Counts complete records and discarded multisamples (both saturating), and latches
// the backup and sync-error flags. A clear pulse starts a fresh frame and wins over
// any event seen in the same cycle.
module evt_status_track #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             drop,
    input  logic             word_acc,
    input  logic             word_sync,
    input  logic             rec_complete,
    output logic [CNT_W-1:0] rec_cnt,
    output logic [CNT_W-1:0] skip_cnt,
    output logic             backup_flag,
    output logic             sync_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Skip count and backup flag: one step per discard pulse, held at CNT_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            skip_cnt    <= '0;
            backup_flag <= 1'b0;
        end else if (drop) begin
            backup_flag <= 1'b1;
            if (skip_cnt != CNT_MAX) skip_cnt <= skip_cnt + 1'b1;
        end
    end

    // Sync flag: sticky once any accepted word reports an address mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)          sync_flag <= 1'b0;
        else if (word_acc && word_sync) sync_flag <= 1'b1;
    end

    // Record count: one step per completed four-word record, held at CNT_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                       rec_cnt <= '0;
        else if (rec_complete && rec_cnt != CNT_MAX) rec_cnt <= rec_cnt + 1'b1;
    end

    AST_SKIP_NEEDS_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cnt != '0) |-> backup_flag); // R7
    AST_SKIP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cnt == CNT_MAX && !clear) |=> (skip_cnt == CNT_MAX)); // R6
    AST_CLEAR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (skip_cnt == '0 && !backup_flag && !sync_flag && rec_cnt == '0)); // R10
endmodule

// File: rtl/evt_frame_builder.sv
// Module: top of the per-trigger event frame builder.
// It sequences header 0, header 1, the timestamp (low half first), the forwarded
// records and the tail. Upstream must hold words until in_ready is high. The end of
// the record phase is taken only at a record boundary with no word on the input.
module evt_frame_builder #(
    parameter int REC_WORDS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              run_start,
    input  logic                              trigger,
    input  logic [ADDR_W-1:0]                 node_addr,
    input  logic                              in_valid,
    input  logic [evt_frame_pkg::DATA_W-1:0]  in_data,
    input  logic                              in_sync_err,
    output logic                              in_ready,
    input  logic                              rec_done,
    input  logic                              drop_pulse,
    output logic                              out_valid,
    output logic [evt_frame_pkg::DATA_W-1:0]  out_data,
    output logic                              out_last
);
    import evt_frame_pkg::*;

    localparam int TS_W  = 2 * DATA_W;
    localparam int IDX_W = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_WORDS - 1);

    seq_state_t       state;
    logic [IDX_W-1:0] word_idx;
    logic [TS_W-1:0]  ts_now;
    logic [TS_W-1:0]  ts_cap;
    logic [CNT_W-1:0] rec_cnt, skip_cnt;
    logic             backup_flag, sync_flag;
    logic             start_frame, word_acc, rec_complete, end_frame;

    assign in_ready     = (state == ST_DATA);
    assign start_frame  = (state == ST_IDLE) && trigger;
    assign word_acc     = in_ready && in_valid;
    assign rec_complete = word_acc && (word_idx == IDX_LAST);
    assign end_frame    = in_ready && !in_valid && rec_done && (word_idx == '0);

    evt_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_start (run_start),
        .ts_now    (ts_now)
    );

    evt_status_track #(.CNT_W(CNT_W)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start_frame),
        .drop         (drop_pulse),
        .word_acc     (word_acc),
        .word_sync    (in_sync_err),
        .rec_complete (rec_complete),
        .rec_cnt      (rec_cnt),
        .skip_cnt     (skip_cnt),
        .backup_flag  (backup_flag),
        .sync_flag    (sync_flag)
    );

    // Sequencer: walks the frame layout and registers each output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            word_idx  <= '0;
            ts_cap    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            case (state)
                ST_IDLE: if (trigger) begin
                    out_valid <= 1'b1;
                    out_data  <= '0;
                    ts_cap    <= ts_now;
                    word_idx  <= '0;
                    state     <= ST_HDR1;
                end
                ST_HDR1: begin
                    out_valid <= 1'b1;
                    out_data  <= DATA_W'(node_addr);
                    state     <= ST_TSLO;
                end
                ST_TSLO: begin
                    out_valid <= 1'b1;
                    out_data  <= ts_cap[DATA_W-1:0];
                    state     <= ST_TSHI;
                end
                ST_TSHI: begin
                    out_valid <= 1'b1;
                    out_data  <= ts_cap[TS_W-1:DATA_W];
                    state     <= ST_DATA;
                end
                ST_DATA: begin
                    if (word_acc) begin
                        out_valid <= 1'b1;
                        out_data  <= in_data;
                        word_idx  <= (word_idx == IDX_LAST) ? '0 : word_idx + 1'b1;
                    end else if (end_frame) begin
                        out_valid <= 1'b1;
                        out_last  <= 1'b1;
                        out_data  <= pack_tail(rec_cnt, skip_cnt, backup_flag, sync_flag);
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_HDR0_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start_frame |=> (out_valid && out_data == '0 && !out_last)); // R1
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_data[31:28] == 4'b0 && out_data[25:24] == 2'b0)); // R9
    AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        word_acc |=> (out_valid && out_data == $past(in_data))); // R3
    AST_MIDREC_END_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && word_idx != '0) |=> !out_last); // R4
endmodule

// File: tb/evt_frame_builder_tb.sv
module evt_frame_builder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_start = 1'b0, trigger = 1'b0;
    logic [7:0]  node_addr = 8'h5C;
    logic        in_valid = 1'b0, in_sync_err = 1'b0, rec_done = 1'b0, drop_pulse = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, out_valid, out_last;
    logic [31:0] out_data;

    int n_vec = 0, n_bad = 0;
    int cyc = 0;
    logic [63:0] ts_model = '0;
    logic [31:0] got_d[$];
    logic        got_l[$];
    int          got_c[$];

    always #5 clk = ~clk;

    evt_frame_builder u_dut (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .trigger(trigger),
        .node_addr(node_addr), .in_valid(in_valid), .in_data(in_data),
        .in_sync_err(in_sync_err), .in_ready(in_ready), .rec_done(rec_done),
        .drop_pulse(drop_pulse), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    // Cycle count and timestamp model taken from R2.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || run_start) ts_model <= '0;
        else                     ts_model <= ts_model + 64'd1;
    end

    // Output collector, sampled away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            got_d.push_back(out_data);
            got_l.push_back(out_last);
            got_c.push_back(cyc);
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int fr, input int m, input int drops, input logic [7:0] smask,
                             input bit gaps, input bit midtest, input bit newrun, input int g);
        logic [63:0] ets;
        int tcyc;
        int nw;
        bit sync_exp;
        int skip_exp;
        logic [31:0] tail;
        if (newrun) begin
            run_start = 1'b1;
            @(negedge clk);
            run_start = 1'b0;
        end
        repeat (g) @(negedge clk);
        got_d.delete(); got_l.delete(); got_c.delete();
        trigger = 1'b1; ets = ts_model; tcyc = cyc;
        @(negedge clk);
        trigger = 1'b0;
        while (!in_ready) @(negedge clk);
        for (int d = 0; d < drops; d++) begin
            drop_pulse = 1'b1;
            @(negedge clk);
        end
        drop_pulse = 1'b0;
        sync_exp = 1'b0;
        for (int r = 0; r < m; r++) begin
            for (int w = 0; w < 4; w++) begin
                in_valid = 1'b1;
                in_data = {8'hD0 ^ 8'(fr), 8'(fr), 8'(r), 8'(w)};
                in_sync_err = smask[r] && (w == 1);
                if (in_sync_err) sync_exp = 1'b1;
                @(negedge clk);
                in_valid = 1'b0; in_sync_err = 1'b0;
                if (gaps && w == 2) @(negedge clk);
                if (midtest && r == 0 && w == 1) begin
                    // R4, R10: end request mid-record and a second trigger are ignored
                    rec_done = 1'b1; trigger = 1'b1;
                    @(negedge clk);
                    rec_done = 1'b0; trigger = 1'b0;
                end
            end
        end
        rec_done = 1'b1;
        @(negedge clk);
        rec_done = 1'b0;
        repeat (4) @(negedge clk);

        nw = 5 + 4 * m;
        chk("R10 frame length", 64'(got_d.size()), 64'(nw));
        if (got_d.size() == nw) begin
            chk("R1 start cycle", 64'(got_c[0]), 64'(tcyc + 1));
            chk("R1 header0", 64'(got_d[0]), 64'd0);
            chk("R1 header1", 64'(got_d[1]), {56'd0, node_addr});
            chk("R2 ts low", 64'(got_d[2]), {32'd0, ets[31:0]});
            chk("R2 ts high", 64'(got_d[3]), {32'd0, ets[63:32]});
            for (int r = 0; r < m; r++)
                for (int w = 0; w < 4; w++)
                    chk("R3 record word", 64'(got_d[4 + 4*r + w]),
                        64'({8'hD0 ^ 8'(fr), 8'(fr), 8'(r), 8'(w)}));
            for (int k = 0; k < nw - 1; k++)
                if (got_l[k]) chk("R4 early last", 64'd1, 64'd0);
            tail = got_d[nw-1];
            skip_exp = (drops > 4095) ? 4095 : drops;
            chk("R4 tail last", 64'(got_l[nw-1]), 64'd1);
            chk("R5 record count", 64'(tail[11:0]), 64'(m));
            chk("R6 skip count", 64'(tail[23:12]), 64'(skip_exp));
            chk("R7 backup flag", 64'(tail[27]), 64'(drops > 0));
            chk("R8 sync flag", 64'(tail[26]), 64'(sync_exp));
            chk("R9 zero bits", 64'({tail[31:28], tail[25:24]}), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int fr;
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", 64'(out_valid), 64'd0);
        chk("R11 reset in_ready", 64'(in_ready), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 idle out_valid", 64'(out_valid), 64'd0);
        chk("R11 idle out_last", 64'(out_last), 64'd0);
        chk("R11 idle in_ready", 64'(in_ready), 64'd0);
        fr = 0;
        for (int m = 0; m <= 5; m++) begin
            for (int di = 0; di < 3; di++) begin
                for (int sp = 0; sp < 3; sp++) begin
                    logic [7:0] sm;
                    sm = (sp == 0) ? 8'h00 : (sp == 1) ? 8'h01 << (m > 0 ? m - 1 : 0) : 8'h0A;
                    node_addr = 8'(8'h31 * fr + 5);
                    run_frame(fr, m, (di == 0) ? 0 : (di == 1) ? 1 : 3, sm,
                              (fr % 2) == 1, 1'b0, (fr % 4) == 0, fr % 5);
                    fr++;
                end
            end
        end
        run_frame(fr, 2, 1, 8'h00, 1'b0, 1'b1, 1'b0, 2); fr++;
        run_frame(fr, 1, 4100, 8'h01, 1'b0, 1'b0, 1'b1, 3); fr++;
        run_frame(fr, 3, 0, 8'h00, 1'b1, 1'b0, 1'b0, 0); fr++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule